// File: doc/BRIEF.md
# Quad-Word Flash Program Sequencer

This block sits between a bus write port and a flash array during programming. Software sets a program-enable control bit and then writes four 32-bit words that together form one 128-bit quad-word. The block checks every write for access size, address placement and write protection. It collects the accepted words in a buffer. When the fourth word arrives, it checks that the target is blank and then sends a single program command to the array. It holds the command data steady until the array reports completion.

A status word keeps sticky error flags and an end-of-operation flag. Software clears each of these by writing 1 to its bit. The status word also shows a busy bit and a wait-data bit. The interrupt request combines the enabled flags. The array is reached through a minimal interface: a one-cycle request, a quad-word index, the data to program, the current contents at that index and a completion pulse.

Top module: `qwp_sequencer`

## Requirements
- R1: After reset, `status` is all zero, `irq` is 0 and `arr_req` is 0.
- R2: A data write whose `wr_size` is not word (0 = byte, 1 = half-word, 2 = word) sets status bit 6, discards the partly filled buffer and starts no array operation.
- R3: The first word of a sequence must have byte address bits [3:0] equal to zero. Each later word must lie in the same quad-word (address bits [19:4]) and have bits [1:0] equal to zero. A violation sets status bit 5 and discards the buffer.
- R4: A data write while `pg_en` is 0 sets status bit 7 and discards the buffer. This check has the highest priority, followed by size (R2), then placement (R3), then protection (R5). Each rejected write sets only the flag of the first check it fails.
- R5: A write whose quad-word index lies in the inclusive range `wp_lo`..`wp_hi` while `wp_en` is 1 sets status bit 4 and discards the buffer.
- R6: Status bit 17 (wait-data) goes to 1 when the first word is accepted. It returns to 0 when the array completes, or when any error discards the buffer.
- R7: In the cycle after the fourth word is accepted, `arr_req` is 1 for exactly one cycle. Status bit 16 (busy) is 1 from that cycle until the edge on which `arr_done` is seen. `arr_addr` and `arr_wdata` carry the quad-word index and data.
- R8: If `arr_cur` is not all ones when the fourth word arrives, and the quad-word to write is not all zeros, status bit 3 is set and no request is issued. All-zero data is always programmed.
- R9: Completion sets status bit 0 only while `eop_ie` is 1. Every error event of R2 to R5 and R8 also sets status bit 1, but only while `err_ie` is 1.
- R10: Status bits 0, 1 and 3 to 7 are sticky. A write with `sr_wr` clears exactly the bits given as 1 in `sr_wdata`; bits given as 0 are unaffected. Bits 2, 14 and all other bits not named above always read 0.
- R11: `irq` is 1 exactly when (bit 0 and `eop_ie`) or (any of bits 1, 3 to 7 and `err_ie`).
- R12: While busy, data writes and status clear writes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pg_en | input | 1 | Program-enable control bit |
| eop_ie | input | 1 | Completion interrupt enable |
| err_ie | input | 1 | Error interrupt enable |
| wp_en | input | 1 | Write-protection window enable |
| wp_lo | input | 16 | First protected quad-word index |
| wp_hi | input | 16 | Last protected quad-word index |
| wr_valid | input | 1 | Data write strobe |
| wr_addr | input | 20 | Byte address of the data write |
| wr_size | input | 2 | Access size code |
| wr_data | input | 32 | Write data word |
| sr_wr | input | 1 | Status clear-write strobe |
| sr_wdata | input | 8 | Write-1-to-clear mask for status bits 7..0 |
| status | output | 32 | Status word |
| irq | output | 1 | Interrupt request |
| arr_req | output | 1 | One-cycle program request to the array |
| arr_addr | output | 16 | Quad-word index being programmed or checked |
| arr_wdata | output | 128 | Quad-word to program |
| arr_cur | input | 128 | Current array contents at `arr_addr` |
| arr_done | input | 1 | Array completion pulse |

## Verification
The assertions rely on three properties of the array side. First, `arr_cur` reflects `arr_addr` within the same cycle. Second, `arr_done` pulses only after a request and while the operation is outstanding. Third, the enable and protection inputs change only between sequences. The bench keeps to these rules in two ways. It uses a stub that returns the contents of its own small memory at the presented index and raises a single done pulse a fixed latency after each request. It also changes the control inputs only while the sequencer is idle and the buffer is empty.

// File: rtl/qwp_pkg.sv
package qwp_pkg;

  // Outcome of checking one data write
  typedef enum logic [2:0] {
    CHK_OK    = 3'd0,
    CHK_SEQ   = 3'd1,
    CHK_SIZE  = 3'd2,
    CHK_ALIGN = 3'd3,
    CHK_WRP   = 3'd4
  } chk_t;

  // Access size codes
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // Status bit positions (software decodes these)
  localparam int B_EOP   = 0;
  localparam int B_OPERR = 1;
  localparam int B_RSVD  = 2;
  localparam int B_PROG  = 3;
  localparam int B_WRP   = 4;
  localparam int B_ALIGN = 5;
  localparam int B_SIZE  = 6;
  localparam int B_SEQ   = 7;
  localparam int B_RDERR = 14;
  localparam int B_BUSY  = 16;
  localparam int B_WDW   = 17;

  localparam int FLAG_W  = 8;
  localparam int STAT_W  = 32;

endpackage

// File: rtl/qwp_access_check.sv
module qwp_access_check
  import qwp_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int QW_LSB = 4,
  parameter int WB_LSB = 2,
  localparam int IDX_W = ADDR_W - QW_LSB
) (
  input  logic              pg_en,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic              first,
  input  logic [IDX_W-1:0]  base,
  input  logic              wp_en,
  input  logic [IDX_W-1:0]  wp_lo,
  input  logic [IDX_W-1:0]  wp_hi,
  output chk_t              verdict
);

  function automatic logic [IDX_W-1:0] qw_index(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:QW_LSB];
  endfunction

  // Word must sit on a word boundary; a leading word also on a quad-word
  // boundary; a trailing word inside the quad-word already opened.
  function automatic logic off_grid(input logic [ADDR_W-1:0] a, input logic lead,
                                    input logic [IDX_W-1:0] b);
    if (a[WB_LSB-1:0] != '0) return 1'b1;
    if (lead) return a[QW_LSB-1:WB_LSB] != '0;
    return qw_index(a) != b;
  endfunction

  function automatic logic in_window(input logic [IDX_W-1:0] i, input logic en,
                                     input logic [IDX_W-1:0] lo, input logic [IDX_W-1:0] hi);
    return en && (i >= lo) && (i <= hi);
  endfunction

  always_comb begin
    if (!pg_en)                                  verdict = CHK_SEQ;
    else if (size != SZ_WORD)                    verdict = CHK_SIZE;
    else if (off_grid(addr, first, base))        verdict = CHK_ALIGN;
    else if (in_window(qw_index(addr), wp_en, wp_lo, wp_hi)) verdict = CHK_WRP;
    else                                         verdict = CHK_OK;
  end

endmodule

// File: rtl/qwp_word_buffer.sv
module qwp_word_buffer #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int IDX_W  = 16,
  localparam int SLOT_W = $clog2(WORDS),
  localparam int QW_W   = DATA_W * WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              drop,
  input  logic              flush,
  input  logic [SLOT_W-1:0] slot,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] word,
  output logic [SLOT_W-1:0] cnt,
  output logic [IDX_W-1:0]  base,
  output logic [QW_W-1:0]   held,
  output logic [QW_W-1:0]   merged,
  output logic              wdw,
  output logic              last
);

  localparam logic [SLOT_W-1:0] LAST_CNT = SLOT_W'(WORDS - 1);

  assign last = take && (cnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      base <= '0;
      wdw  <= 1'b0;
    end else if (drop) begin
      cnt  <= '0;
      wdw  <= 1'b0;
    end else begin
      if (take) begin
        if (cnt == '0) base <= idx;
        cnt <= last ? '0 : cnt + 1'b1;
        wdw <= 1'b1;
      end
      if (flush) wdw <= 1'b0;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_slot
    logic hit;
    assign hit = take && (slot == SLOT_W'(g));
    assign merged[g*DATA_W +: DATA_W] = hit ? word : held[g*DATA_W +: DATA_W];
    always_ff @(posedge clk) begin
      if (!rst_n)   held[g*DATA_W +: DATA_W] <= '0;
      else if (hit) held[g*DATA_W +: DATA_W] <= word;
    end
  end

endmodule

// File: rtl/qwp_status_reg.sv
module qwp_status_reg
  import qwp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] set_ev,
  input  logic              clr_en,
  input  logic [FLAG_W-1:0] clr_mask,
  input  logic              busy,
  input  logic              wdw,
  input  logic              eop_ie,
  input  logic              err_ie,
  output logic [STAT_W-1:0] status,
  output logic              irq
);

  localparam logic [FLAG_W-1:0] LIVE = ~(FLAG_W'(1) << B_RSVD);

  logic [FLAG_W-1:0] flags_q;
  logic [FLAG_W-1:0] clr;

  assign clr = clr_en ? (clr_mask & LIVE) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= ((flags_q & ~clr) | set_ev) & LIVE;
  end

  always_comb begin
    status          = '0;
    status[FLAG_W-1:0] = flags_q;
    status[B_RDERR] = 1'b0;
    status[B_BUSY]  = busy;
    status[B_WDW]   = wdw;
  end

  assign irq = (flags_q[B_EOP] && eop_ie) ||
               ((flags_q[FLAG_W-1:B_OPERR] != '0) && err_ie);

  // R10: a flag that was not cleared stays set
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & ~clr) != '0) |=> ((flags_q & $past(flags_q & ~clr)) == $past(flags_q & ~clr)));

  // R9: completion flag cannot appear while its enable is low
  a_r9_eop_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags_q[B_EOP] && !eop_ie) |=> !flags_q[B_EOP]);

  // R11: no request with both enables low
  a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!eop_ie && !err_ie) |-> !irq);

endmodule

// File: rtl/qwp_sequencer.sv
module qwp_sequencer
  import qwp_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  localparam int WB_LSB = $clog2(DATA_W / 8),
  localparam int QW_LSB = $clog2(WORDS * DATA_W / 8),
  localparam int IDX_W  = ADDR_W - QW_LSB,
  localparam int SLOT_W = $clog2(WORDS),
  localparam int QW_W   = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_en,
  input  logic              eop_ie,
  input  logic              err_ie,
  input  logic              wp_en,
  input  logic [IDX_W-1:0]  wp_lo,
  input  logic [IDX_W-1:0]  wp_hi,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_size,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sr_wr,
  input  logic [FLAG_W-1:0] sr_wdata,
  output logic [STAT_W-1:0] status,
  output logic              irq,
  output logic              arr_req,
  output logic [IDX_W-1:0]  arr_addr,
  output logic [QW_W-1:0]   arr_wdata,
  input  logic [QW_W-1:0]   arr_cur,
  input  logic              arr_done
);

  // Target must be blank unless the new data is all zeros
  function automatic logic needs_rewrite(input logic [QW_W-1:0] cur, input logic [QW_W-1:0] nxt);
    return !(&cur) && (|nxt);
  endfunction

  logic              busy_q, req_q, wdw;
  logic [SLOT_W-1:0] cnt;
  logic [IDX_W-1:0]  base;
  logic [QW_W-1:0]   held, merged;
  chk_t              verdict;
  logic              acc, take, last, prog_bad, launch, err_evt, done_ok;
  logic [FLAG_W-1:0] set_ev;

  assign acc = wr_valid && !busy_q;

  qwp_access_check #(.ADDR_W(ADDR_W), .QW_LSB(QW_LSB), .WB_LSB(WB_LSB)) u_chk (
    .pg_en  (pg_en),
    .size   (wr_size),
    .addr   (wr_addr),
    .first  (cnt == '0),
    .base   (base),
    .wp_en  (wp_en),
    .wp_lo  (wp_lo),
    .wp_hi  (wp_hi),
    .verdict(verdict)
  );

  assign take     = acc && (verdict == CHK_OK);
  assign prog_bad = last && needs_rewrite(arr_cur, merged);
  assign launch   = last && !prog_bad;
  assign err_evt  = (acc && (verdict != CHK_OK)) || prog_bad;
  assign done_ok  = busy_q && arr_done;

  qwp_word_buffer #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .drop  (err_evt),
    .flush (done_ok),
    .slot  (wr_addr[QW_LSB-1:WB_LSB]),
    .idx   (wr_addr[ADDR_W-1:QW_LSB]),
    .word  (wr_data),
    .cnt   (cnt),
    .base  (base),
    .held  (held),
    .merged(merged),
    .wdw   (wdw),
    .last  (last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      req_q <= launch;
      if (launch)       busy_q <= 1'b1;
      else if (done_ok) busy_q <= 1'b0;
    end
  end

  always_comb begin
    set_ev          = '0;
    set_ev[B_SEQ]   = acc && (verdict == CHK_SEQ);
    set_ev[B_SIZE]  = acc && (verdict == CHK_SIZE);
    set_ev[B_ALIGN] = acc && (verdict == CHK_ALIGN);
    set_ev[B_WRP]   = acc && (verdict == CHK_WRP);
    set_ev[B_PROG]  = prog_bad;
    set_ev[B_OPERR] = err_evt && err_ie;
    set_ev[B_EOP]   = done_ok && eop_ie;
  end

  qwp_status_reg u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_ev  (set_ev),
    .clr_en  (sr_wr && !busy_q),
    .clr_mask(sr_wdata),
    .busy    (busy_q),
    .wdw     (wdw),
    .eop_ie  (eop_ie),
    .err_ie  (err_ie),
    .status  (status),
    .irq     (irq)
  );

  assign arr_req   = req_q;
  assign arr_addr  = base;
  assign arr_wdata = held;

  // R7: request lasts one cycle and is covered by busy
  a_r7_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req |=> !arr_req);
  a_r7_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req |-> status[B_BUSY]);

  // R6: an outstanding operation always has buffered data
  a_r6_busy_wdw: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> wdw);

  // R12: command held steady while the array works
  a_r12_hold_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !arr_done) |=> ($stable(arr_wdata) && $stable(arr_addr)));

  // R8: a dirty target never launches
  a_r8_dirty_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
    prog_bad |=> (!arr_req && !busy_q));

endmodule

// File: tb/sim_qwp_sequencer.sv
`timescale 1ns/1ps
module sim_qwp_sequencer;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pg_en = 1'b0, eop_ie = 1'b0, err_ie = 1'b0, wp_en = 1'b0;
  logic [15:0]  wp_lo = 16'd0, wp_hi = 16'd0;
  logic         wr_valid = 1'b0;
  logic [19:0]  wr_addr = 20'd0;
  logic [1:0]   wr_size = 2'd0;
  logic [31:0]  wr_data = 32'd0;
  logic         sr_wr = 1'b0;
  logic [7:0]   sr_wdata = 8'd0;
  logic [31:0]  status;
  logic         irq, arr_req, arr_done;
  logic [15:0]  arr_addr;
  logic [127:0] arr_wdata, arr_cur;

  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  qwp_sequencer u0 (.*);

  // Behavioural array stub: 16 quad-words, fixed latency
  logic [127:0] mem [16];
  int lat = 0;
  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '1;
    arr_done = 1'b0;
  end
  assign arr_cur = mem[arr_addr[3:0]];
  always @(posedge clk) begin
    arr_done <= 1'b0;
    if (arr_req) lat <= 3;
    else if (lat > 0) begin
      lat <= lat - 1;
      if (lat == 1) begin
        arr_done <= 1'b1;
        mem[arr_addr[3:0]] <= mem[arr_addr[3:0]] & arr_wdata;
      end
    end
  end

  // Reference model
  logic [7:0]  m_fl;
  logic        m_busy, m_wdw, m_req;
  logic [1:0]  m_cnt;
  logic [15:0] m_base;
  logic [31:0] m_w [4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_fl = 8'h0; m_busy = 1'b0; m_wdw = 1'b0; m_req = 1'b0;
      m_cnt = 2'd0; m_base = 16'd0;
      for (int i = 0; i < 4; i++) m_w[i] = 32'h0;
    end else begin
      automatic logic [7:0] set = 8'h0;
      automatic logic [7:0] clr = 8'h0;
      automatic int code = 0;
      automatic logic go = 1'b0;
      automatic logic was_busy = m_busy;
      automatic logic [15:0] qi = wr_addr[19:4];
      if (wr_valid && !was_busy) begin
        if (!pg_en) code = 7;
        else if (wr_size != 2'd2) code = 6;
        else if (wr_addr[1:0] != 2'd0) code = 5;
        else if (m_cnt == 2'd0 && wr_addr[3:2] != 2'd0) code = 5;
        else if (m_cnt != 2'd0 && qi != m_base) code = 5;
        else if (wp_en && qi >= wp_lo && qi <= wp_hi) code = 4;
        if (code == 0) begin
          if (m_cnt == 2'd0) m_base = qi;
          m_w[wr_addr[3:2]] = wr_data;
          m_wdw = 1'b1;
          if (m_cnt == 2'd3) begin
            automatic logic [127:0] qw = {m_w[3], m_w[2], m_w[1], m_w[0]};
            if (mem[m_base[3:0]] != '1 && qw != '0) code = 3;
            else go = 1'b1;
            m_cnt = 2'd0;
          end else m_cnt = m_cnt + 2'd1;
        end
        if (code != 0) begin
          set[code] = 1'b1;
          if (err_ie) set[1] = 1'b1;
          m_cnt = 2'd0; m_wdw = 1'b0;
        end
      end
      if (was_busy && arr_done) begin
        m_busy = 1'b0; m_wdw = 1'b0;
        if (eop_ie) set[0] = 1'b1;
      end
      if (sr_wr && !was_busy) clr = sr_wdata & 8'hFB;
      m_fl = (m_fl & ~clr) | set;
      if (go) m_busy = 1'b1;
      m_req = go;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle compare, away from the clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 eop",      32'(status[0]),  32'(m_fl[0]));
      chk("R9 operr",    32'(status[1]),  32'(m_fl[1]));
      chk("R8 progerr",  32'(status[3]),  32'(m_fl[3]));
      chk("R5 wrperr",   32'(status[4]),  32'(m_fl[4]));
      chk("R3 alignerr", 32'(status[5]),  32'(m_fl[5]));
      chk("R2 sizeerr",  32'(status[6]),  32'(m_fl[6]));
      chk("R4 seqerr",   32'(status[7]),  32'(m_fl[7]));
      chk("R7 busy",     32'(status[16]), 32'(m_busy));
      chk("R6 wdw",      32'(status[17]), 32'(m_wdw));
      chk("R10 zeros",   status & 32'hFFFC_FF04, 32'h0);
      chk("R7 arr_req",  32'(arr_req),    32'(m_req));
      chk("R11 irq",     32'(irq),
          32'((m_fl[0] && eop_ie) || ((m_fl[7:1] != 7'd0) && err_ie)));
    end
  end

  task automatic wr(input logic [19:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk); #1;
    wr_valid = 1'b1; wr_addr = a; wr_size = sz; wr_data = d;
    @(negedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic clear(input logic [7:0] m);
    @(negedge clk); #1;
    sr_wr = 1'b1; sr_wdata = m;
    @(negedge clk); #1;
    sr_wr = 1'b0;
  endtask

  task automatic prog_qw(input int qi, input logic [31:0] seed);
    for (int k = 0; k < 4; k++) wr(20'(qi * 16 + k * 4), 2'd2, seed + 32'(k));
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 40 && status[16]; n++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", status, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 arr_req", 32'(arr_req), 32'h0);
    #1 rst_n = 1'b1; pg_en = 1'b1; eop_ie = 1'b1; err_ie = 1'b1;
    wp_lo = 16'd5; wp_hi = 16'd6; wp_en = 1'b1;
    mem[2] = 128'h0000_1111_2222_3333_4444_5555_6666_7777;

    // R7 R6 R9: clean program
    prog_qw(1, 32'hA5A5_0000);
    wait_idle();
    chk("R9 eop set", status & 32'h1, 32'h1);
    chk("R7 array written", mem[1][31:0], 32'hA5A5_0000);

    // R10: write 0 keeps, write 1 clears
    clear(8'h00);
    chk("R10 zero write keeps", status & 32'h1, 32'h1);
    clear(8'h01);
    chk("R10 one write clears", status & 32'h1, 32'h0);

    // R2: byte access mid-sequence
    wr(20'h00030, 2'd2, 32'h1);
    wr(20'h00034, 2'd0, 32'h2);
    chk("R2 size flag, buffer gone", status & 32'h2_0040, 32'h40);
    clear(8'hFF);

    // R3: misaligned leader, then stray follower
    wr(20'h00024, 2'd2, 32'h3);
    chk("R3 leader align", status & 32'h20, 32'h20);
    wr(20'h00020, 2'd2, 32'h4);
    wr(20'h00034, 2'd2, 32'h5);
    chk("R3 follower align, R6 wdw drop", status & 32'h2_0020, 32'h20);
    clear(8'hFF);

    // R4: no program enable
    #1 pg_en = 1'b0;
    wr(20'h00040, 2'd0, 32'h6);
    chk("R4 seq has priority", status & 32'hF0, 32'h80);
    #1 pg_en = 1'b1;
    clear(8'hFF);

    // R5: protected window
    wr(20'h00050, 2'd2, 32'h7);
    chk("R5 wrp flag", status & 32'h12, 32'h12);
    clear(8'hFF);

    // R8: dirty target, then all-zero data
    prog_qw(2, 32'h0000_0100);
    chk("R8 prog flag no busy", status & 32'h1_0008, 32'h8);
    clear(8'hFF);
    for (int k = 0; k < 4; k++) wr(20'(32 + k * 4), 2'd2, 32'h0);
    wait_idle();
    chk("R8 zeros programmed", 32'(mem[2] == 128'h0), 32'h1);
    clear(8'hFF);

    // R9 R11: enables gate flags and irq
    #1 eop_ie = 1'b0; err_ie = 1'b0;
    prog_qw(3, 32'h0BAD_0000);
    wait_idle();
    wr(20'h00041, 2'd2, 32'h8);
    chk("R9 gated flags", status & 32'h23, 32'h20);
    chk("R11 irq low", 32'(irq), 32'h0);
    #1 err_ie = 1'b1;
    @(negedge clk);
    chk("R11 irq from enabled error", 32'(irq), 32'h1);
    clear(8'hFF);

    // R12: writes ignored while busy
    #1 pg_en = 1'b0;
    wr(20'h00070, 2'd2, 32'h9);
    #1 pg_en = 1'b1;
    prog_qw(4, 32'h7700_0000);
    wr(20'h00080, 2'd0, 32'hA);
    clear(8'hFF);
    wait_idle();
    chk("R12 flags kept while busy", status & 32'hC2, 32'h82);
    clear(8'hFF);
    repeat (3) @(negedge clk);
    finish_up();
  end

endmodule